// File: doc/BRIEF.md
# Decimating six-channel input sequencer

The block accepts a stream of 10-bit binary pixel words and deals consecutive words out to six channels. Every channel holds two registers: a load register that captures the word meant for it during a fill sequence, and an output register that all six channels refresh together on a transfer. A new row of six words can therefore be loaded while the previous row is still presented at the outputs. A start strobe begins a fill, a direction input picks which end channel is filled first, and a transfer strobe moves the whole row of load registers into the output registers.

The pixel clock is not used as a clock. A faster system clock samples it through a two-flop synchroniser and derives rise and fall strobes from it. An edge-select input chooses whether data and start are taken on pixel rising or falling edges; the transfer strobe always works on rising edges. Each word carries the current invert flag with it, and the flag appears beside the word at the output. A standby input freezes the block.

Top module: `decim_seq`

## Requirements
- R1: While reset is asserted and after its release, all output words, all polarity flags and the busy flag are 0.
- R2: With edgeSel high, dataIn, startIn, dirSel and invIn are taken on pixel rising edges; with edgeSel low they are taken on pixel falling edges.
- R3: A start seen high on an active edge loads nothing on that edge, sets busy, and the first word of the fill is captured on the following active edge; busy returns low after the sixth word is captured.
- R4: dirSel, taken with the start, selects fill order: 0 fills channel 0 first then 1,2,3,4,5; 1 fills channel 5 first then 4,3,2,1,0. Output channel i occupies chanOut bits [10*i+9:10*i].
- R5: Once six words are loaded, further words are ignored and the load registers hold until the next start.
- R6: A start seen during a fill abandons it and restarts from the end channel chosen by dirSel at that start; channels already written keep their words until overwritten.
- R7: xferIn is sampled on every pixel rising edge regardless of edgeSel; on the next rising edge all six load registers (words and flags) are copied to the outputs, using the load values from before any load on that same edge.
- R8: Output words and flags change only on a transfer; loading alone never alters them.
- R9: invIn is captured together with each word; polOut bit i is the flag captured with the word of channel i, and reaches the output with that word on a transfer.
- R10: While stbyIn is high no word is loaded, no start or transfer is taken, busy and the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixClk | input | 1 | Pixel clock, sampled as data |
| dataIn | input | 10 | Pixel word, binary coded |
| startIn | input | 1 | Start-of-fill strobe |
| xferIn | input | 1 | Transfer strobe |
| dirSel | input | 1 | Fill direction: 0 from channel 0, 1 from channel 5 |
| edgeSel | input | 1 | Active pixel edge for loading: 1 rising, 0 falling |
| invIn | input | 1 | Polarity flag carried with each word |
| stbyIn | input | 1 | Standby, freezes the block when high |
| chanOut | output | 60 | Six output words, channel i at bits [10*i+9:10*i] |
| polOut | output | 6 | Polarity flag per channel |
| busy | output | 1 | High while a fill sequence is in progress |

## Verification
The assertions assume the pixel clock is at least several system clocks long in each phase, so that the synchronised edges are separated and every data or strobe input is steady when its edge strobe fires. The stimulus keeps the pixel period at eight system clocks, moves each input half a pixel period away from the edge that samples it, and changes edgeSel and stbyIn only when no fill or transfer is pending. Under those conditions the checks tie output changes to transfer strobes, transfers to synchronised rising edges, and loads to an active fill.

// File: rtl/decim_pkg.sv
package decim_pkg;
  parameter int CHANS = 6;
  parameter int WORDW = 10;
  localparam int IDXW = $clog2(CHANS);
  localparam int OUTW = CHANS * WORDW;

  typedef struct packed {
    logic            loadEn;
    logic [IDXW-1:0] loadIdx;
    logic            xferEn;
  } seqStrb_t;
endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     pixClk,
  input  logic     edgeSel,
  input  logic     startIn,
  input  logic     xferIn,
  input  logic     dirSel,
  input  logic     stbyIn,
  output seqStrb_t strb,
  output logic     busy
);
  localparam logic [IDXW-1:0] LAST = IDXW'(CHANS - 1);

  logic [2:0]      pixSync;
  logic            pixRise, pixFall, actEdge;
  logic            busyR, dirR, xferPend;
  logic [IDXW-1:0] cnt;

  // two synchroniser flops plus one history flop for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) pixSync <= '0;
    else       pixSync <= {pixSync[1:0], pixClk};
  end

  assign pixRise = pixSync[1] & ~pixSync[2];
  assign pixFall = ~pixSync[1] & pixSync[2];
  assign actEdge = edgeSel ? pixRise : pixFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR    <= 1'b0;
      dirR     <= 1'b0;
      cnt      <= '0;
      xferPend <= 1'b0;
    end else if (!stbyIn) begin
      if (actEdge) begin
        if (startIn) begin
          busyR <= 1'b1;
          cnt   <= '0;
          dirR  <= dirSel;
        end else if (busyR) begin
          if (cnt == LAST) begin
            busyR <= 1'b0;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      if (pixRise) xferPend <= xferIn;
    end
  end

  always_comb begin
    strb.loadEn  = actEdge & busyR & ~startIn & ~stbyIn;
    strb.loadIdx = dirR ? (LAST - cnt) : cnt;
    strb.xferEn  = pixRise & xferPend & ~stbyIn;
  end

  assign busy = busyR;
endmodule

// File: rtl/decim_data.sv
module decim_data
  import decim_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrb_t         strb,
  input  logic [WORDW-1:0] dataIn,
  input  logic             invIn,
  output logic [OUTW-1:0]  chanOut,
  output logic [CHANS-1:0] polOut
);
  for (genvar i = 0; i < CHANS; i++) begin : gChan
    logic [WORDW-1:0] loadWord, outWord;
    logic             loadPol, outPol;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loadWord <= '0;
        loadPol  <= 1'b0;
        outWord  <= '0;
        outPol   <= 1'b0;
      end else begin
        if (strb.loadEn && strb.loadIdx == IDXW'(i)) begin
          loadWord <= dataIn;
          loadPol  <= invIn;
        end
        if (strb.xferEn) begin
          outWord <= loadWord;
          outPol  <= loadPol;
        end
      end
    end

    assign chanOut[i*WORDW +: WORDW] = outWord;
    assign polOut[i] = outPol;
  end
endmodule

// File: rtl/decim_seq.sv
module decim_seq
  import decim_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pixClk,
  input  logic [WORDW-1:0] dataIn,
  input  logic             startIn,
  input  logic             xferIn,
  input  logic             dirSel,
  input  logic             edgeSel,
  input  logic             invIn,
  input  logic             stbyIn,
  output logic [OUTW-1:0]  chanOut,
  output logic [CHANS-1:0] polOut,
  output logic             busy
);
  seqStrb_t strb;

  decim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pixClk(pixClk), .edgeSel(edgeSel),
    .startIn(startIn), .xferIn(xferIn), .dirSel(dirSel), .stbyIn(stbyIn),
    .strb(strb), .busy(busy)
  );

  decim_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .dataIn(dataIn), .invIn(invIn),
    .chanOut(chanOut), .polOut(polOut)
  );
endmodule

// File: rtl/decim_seq_chk.sv
module decim_seq_chk
  import decim_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            pixClk,
  input logic            stbyIn,
  input logic            busy,
  input logic [OUTW-1:0] chanOut,
  input logic [CHANS-1:0] polOut,
  input seqStrb_t        strb
);
  logic [2:0] seen;
  logic       seenRise;

  always_ff @(posedge clk) begin
    if (!rstN) seen <= '0;
    else       seen <= {seen[1:0], pixClk};
  end
  assign seenRise = seen[1] & ~seen[2];

  // R7: transfers happen only on synchronised rising pixel edges
  assert_xfer_on_rise_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.xferEn |-> seenRise);

  // R8: outputs stay put unless a transfer strobe fired
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.xferEn |=> ($stable(chanOut) && $stable(polOut)));

  // R10: standby freezes outputs and busy
  assert_stby_freeze_R10: assert property (@(posedge clk) disable iff (!rstN)
    stbyIn |=> ($stable(chanOut) && $stable(busy)));

  // R5: no load outside an active fill
  assert_no_load_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.loadEn);

  // R4: load index stays within the channel range
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |-> (strb.loadIdx < IDXW'(CHANS)));
endmodule

bind decim_seq decim_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .pixClk(pixClk), .stbyIn(stbyIn), .busy(busy),
  .chanOut(chanOut), .polOut(polOut), .strb(strb)
);

// File: tb/decim_seq_tb.sv
`timescale 1ns/1ps
module decim_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pixClk = 1'b0;
  logic [9:0]  dataIn = '0;
  logic        startIn = 1'b0, xferIn = 1'b0, dirSel = 1'b0;
  logic        edgeSel = 1'b1, invIn = 1'b0, stbyIn = 1'b0;
  logic [59:0] chanOut;
  logic [5:0]  polOut;
  logic        busy;

  decim_seq u_dut (
    .clk(clk), .rstN(rstN), .pixClk(pixClk), .dataIn(dataIn),
    .startIn(startIn), .xferIn(xferIn), .dirSel(dirSel), .edgeSel(edgeSel),
    .invIn(invIn), .stbyIn(stbyIn), .chanOut(chanOut), .polOut(polOut),
    .busy(busy)
  );

  always #10 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  string curReq = "R1";

  // reference model
  logic [59:0] m1W = '0, m2W = '0;
  logic [5:0]  m1P = '0, m2P = '0;
  logic        mBusy = 1'b0, mDir = 1'b0, mXp = 1'b0;
  int          mCnt = 0;
  logic        mEdge = 1'b1, mStby = 1'b0;

  logic [66:0] expQ [$];
  event        chkEv;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelLoad(input logic [9:0] d, input logic st, input logic dr, input logic iv);
    int idx;
    if (st) begin
      mBusy = 1'b1; mCnt = 0; mDir = dr;
    end else if (mBusy) begin
      idx = mDir ? 5 - mCnt : mCnt;
      m1W[idx*10 +: 10] = d;
      m1P[idx] = iv;
      if (mCnt == 5) begin mBusy = 1'b0; mCnt = 0; end
      else mCnt++;
    end
  endtask

  // one pixel period, entered and left with pixClk low
  task automatic step(input logic [9:0] d, input logic st, input logic xf,
                      input logic dr, input logic iv);
    xferIn = xf;
    if (mEdge) begin dataIn = d; startIn = st; dirSel = dr; invIn = iv; end
    #80 pixClk = 1'b1;
    if (!mStby) begin
      if (mXp) begin m2W = m1W; m2P = m1P; end
      mXp = xf;
      if (mEdge) modelLoad(d, st, dr, iv);
    end
    expQ.push_back({m2P, m2W, mBusy});
    if (!mEdge) begin dataIn = d; startIn = st; dirSel = dr; invIn = iv; end
    #70 -> chkEv;
    #10 pixClk = 1'b0;
    if (!mStby && !mEdge) modelLoad(d, st, dr, iv);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(10'd0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic fill(input logic dr, input int base, input int n);
    step(10'd0, 1'b1, 1'b0, dr, 1'b0);
    for (int k = 0; k < n; k++) step(10'(base + 7*k), 1'b0, 1'b0, dr, k[0]);
  endtask

  task automatic xfer();
    step(10'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    idle(1);
  endtask

  // scoreboard monitor
  always @(chkEv) begin
    while (expQ.size() > 0) begin
      logic [66:0] e;
      e = expQ.pop_front();
      check({curReq, " words"}, 64'(chanOut), 64'(e[60:1]));
      check({curReq, " pol"},   64'(polOut),  64'(e[66:61]));
      check({curReq, " busy"},  64'(busy),    64'(e[0]));
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

  initial begin
    #25 rstN = 1'b1;
    #35;
    curReq = "R1";
    check("R1 words", 64'(chanOut), 64'd0);
    check("R1 pol",   64'(polOut),  64'd0);
    check("R1 busy",  64'(busy),    64'd0);
    #5;
    idle(2);

    // rising edge mode, fill from channel 0
    curReq = "R3"; fill(1'b0, 100, 6);
    curReq = "R5";
    step(10'h3ff, 1'b0, 1'b0, 1'b0, 1'b1);
    step(10'h2aa, 1'b0, 1'b0, 1'b0, 1'b1);
    curReq = "R7"; xfer();
    curReq = "R9"; idle(1);

    // fill from channel 5 while outputs hold the previous row
    curReq = "R8"; fill(1'b1, 300, 6);
    curReq = "R4"; xfer();

    // transfer armed on the same rising edge as the last load
    curReq = "R7";
    step(10'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 5; k++) step(10'(500 + k), 1'b0, 1'b0, 1'b0, 1'b1);
    step(10'd555, 1'b0, 1'b1, 1'b0, 1'b0);
    step(10'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    xfer();

    // restart mid fill
    curReq = "R6";
    fill(1'b0, 600, 3);
    fill(1'b1, 700, 6);
    xfer();

    // falling edge mode
    curReq = "R2";
    edgeSel = 1'b0; mEdge = 1'b0;
    idle(2);
    fill(1'b0, 800, 6);
    idle(1);
    xfer();
    fill(1'b1, 40, 4);
    idle(1);
    fill(1'b1, 900, 6);
    idle(1);
    xfer();
    idle(1);
    edgeSel = 1'b1; mEdge = 1'b1;
    idle(2);

    // standby
    curReq = "R10";
    fill(1'b0, 200, 6);
    stbyIn = 1'b1; mStby = 1'b1;
    fill(1'b1, 20, 6);
    step(10'd0, 1'b0, 1'b1, 1'b0, 1'b0);
    step(10'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    step(10'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    idle(1);
    stbyIn = 1'b0; mStby = 1'b0;
    idle(1);
    xfer();
    idle(1);

    finishRun();
  end
endmodule